// File: doc/BRIEF.md
# Multi-Bit Macro Instruction Sequencer

This block turns a short stored routine into a stream of single-bit cell instructions and issues at most one instruction per clock. A host controller first writes instruction templates into a small microcode store. It then starts a routine by giving the address of the routine's first word. From that point the sequencer walks the store in order. A word can be issued more than once. On each repeat the register-address field of the instruction goes up by one, so one stored template can carry out an n-bit bit-serial add or copy. A routine finishes at the first word whose end flag is set.

When no routine is running, the host can send a single cell instruction straight to the output and skip the store. The output is a valid/ready stream. `out_valid` never depends on `out_ready`. An instruction counts as issued only in a cycle where both are high. While `out_ready` is low, the sequencer holds its position and keeps the presented instruction unchanged. The direct-broadcast input is also valid/ready. Its `dir_ready` is high only when the sequencer is idle, no start request is present and the array side is ready. The host sees `busy` while a routine is in progress and a one-cycle `done` pulse after the routine ends.

A typical multi-bit add routine has two words. The first clears the carry flag and is issued once. The second holds the add template with the repeat count set to n-1. That template walks from the least significant bit upwards, one bit per issued cycle.

Top module: `bitser_macro_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, `busy`, `done` and `out_valid` are all low.
- R2: A `start` request while idle sets `busy` at the next clock edge. From that cycle on, the output presents the word stored at `start_addr`, with its address field unchanged.
- R3: Each stored word is issued as many times as its repeat count asks. The routine then moves to the word at the next store address, which wraps around the store depth.
- R4: A microcode word holds the instruction in bits [34:0], a repeat count r in bits [41:35] and the end flag in bit 42. The word is issued r+1 times. Issue k (counting from 0) carries instruction bits [6:0] plus k, modulo 128. Bits [34:7] stay unchanged.
- R5: After the last issue of a word that has its end flag set, `busy` falls at the next edge. `done` is high for exactly that one following cycle.
- R6: A `start` request while `busy` is high has no effect on the running routine or on its output sequence.
- R7: While `busy` is high and `out_ready` is low, `out_valid` stays high. The presented instruction and the sequencer's position do not change.
- R8: While idle, a direct instruction with `dir_valid` high appears unchanged on `out_instr`, with `out_valid` high and `dir_ready` equal to `out_ready`. While busy, `dir_ready` is low and the direct input does not reach the output.
- R9: In an idle cycle where `start` and `dir_valid` are both high, the start request is taken. `dir_ready` and `out_valid` are low in that cycle.
- R10: When `uc_we` is high, `uc_wdata` is stored at `uc_waddr` at the clock edge. A later routine started there issues the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uc_we | input | 1 | Microcode store write enable |
| uc_waddr | input | 6 | Microcode store write address |
| uc_wdata | input | 43 | Microcode word: end flag, repeat count, instruction |
| start | input | 1 | Routine start request |
| start_addr | input | 6 | Address of the routine's first word |
| dir_valid | input | 1 | Direct instruction offered by the host |
| dir_instr | input | 35 | Direct instruction |
| dir_ready | output | 1 | Direct instruction accepted this cycle when high together with dir_valid |
| out_valid | output | 1 | Cell instruction present |
| out_instr | output | 35 | Broadcast cell instruction |
| out_ready | input | 1 | Cell array accepts the instruction |
| busy | output | 1 | Routine in progress |
| done | output | 1 | One-cycle pulse after a routine ends |

## Verification
The routines tried are:
- a two-word add, where a carry-clear word is followed by an eight-fold repeat;
- a copy repeated 128 times starting at address 120, which shows whether the address field wraps at 7 bits without carrying into bit 7;
- a three-word chain of mixed repeat counts, which separates moving to the next word from repeating the current one.

A long stretch with `out_ready` held low, and a run with `out_ready` toggling at random, separate a correct stall from a skipped or duplicated issue. Direct broadcasts are offered while idle, while busy and in the same cycle as a start, which shows the priority between the two sources.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  parameter int INSTR_W   = 35;
  parameter int REP_W     = 7;
  parameter int FIELD_LSB = 0;
  parameter int FIELD_W   = 7;

  typedef struct packed {
    logic               last;
    logic [REP_W-1:0]   rep;
    logic [INSTR_W-1:0] op;
  } uword_t;

  localparam int WORD_W = $bits(uword_t);
endpackage

// File: rtl/mbs_ucode_store.sv
module mbs_ucode_store
  import mbs_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PC_W = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [PC_W-1:0] waddr,
  input  uword_t          wdata,
  input  logic [PC_W-1:0] raddr,
  output uword_t          rdata
);
  uword_t words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  always_comb rdata = words[raddr];
endmodule

// File: rtl/mbs_field_step.sv
module mbs_field_step
  import mbs_pkg::*;
#(
  parameter int LSB = FIELD_LSB,
  parameter int FW  = FIELD_W,
  parameter int OW  = REP_W
) (
  input  logic [INSTR_W-1:0] op_in,
  input  logic [OW-1:0]      offset,
  output logic [INSTR_W-1:0] op_out
);
  generate
    if (FW > 0) begin : g_step
      logic [FW-1:0] field_sum;
      always_comb begin
        field_sum = op_in[LSB +: FW] + FW'(offset);
        op_out = op_in;
        op_out[LSB +: FW] = field_sum;
      end
    end else begin : g_pass
      always_comb op_out = op_in;
    end
  endgenerate
endmodule

// File: rtl/mbs_seq_ctrl.sv
module mbs_seq_ctrl
  import mbs_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PC_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PC_W-1:0]  start_addr,
  input  logic             out_ready,
  input  logic [REP_W-1:0] word_rep,
  input  logic             word_last,
  output logic             busy,
  output logic             done,
  output logic [PC_W-1:0]  pc,
  output logic [REP_W-1:0] off
);
  localparam logic [REP_W-1:0] OFF_ONE = REP_W'(1);
  localparam logic [PC_W-1:0]  PC_ONE  = PC_W'(1);

  logic issue, word_over;
  assign issue     = busy && out_ready;
  assign word_over = (off == word_rep);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      pc   <= '0;
      off  <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (issue) begin
          if (word_over) begin
            off <= '0;
            if (word_last) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              pc <= pc + PC_ONE;
            end
          end else begin
            off <= off + OFF_ONE;
          end
        end
      end else if (start) begin
        busy <= 1'b1;
        pc   <= start_addr;
        off  <= '0;
      end
    end
  end

  AST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy && pc == $past(start_addr) && off == '0); // R2
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && out_ready && off != word_rep |=> busy && off == $past(off) + OFF_ONE); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && out_ready && off != word_rep |=> pc == $past(pc)); // R6
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !out_ready |=> busy && $stable(pc) && $stable(off)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy)); // R5
endmodule

// File: rtl/bitser_macro_seq.sv
module bitser_macro_seq
  import mbs_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PC_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               uc_we,
  input  logic [PC_W-1:0]    uc_waddr,
  input  logic [WORD_W-1:0]  uc_wdata,
  input  logic               start,
  input  logic [PC_W-1:0]    start_addr,
  input  logic               dir_valid,
  input  logic [INSTR_W-1:0] dir_instr,
  output logic               dir_ready,
  output logic               out_valid,
  output logic [INSTR_W-1:0] out_instr,
  input  logic               out_ready,
  output logic               busy,
  output logic               done
);
  uword_t             cur_word;
  logic [PC_W-1:0]    pc;
  logic [REP_W-1:0]   off;
  logic [INSTR_W-1:0] stepped_op;

  mbs_ucode_store #(.DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (uc_we),
    .waddr (uc_waddr),
    .wdata (uword_t'(uc_wdata)),
    .raddr (pc),
    .rdata (cur_word)
  );

  mbs_seq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .out_ready  (out_ready),
    .word_rep   (cur_word.rep),
    .word_last  (cur_word.last),
    .busy       (busy),
    .done       (done),
    .pc         (pc),
    .off        (off)
  );

  mbs_field_step u_step (
    .op_in  (cur_word.op),
    .offset (off),
    .op_out (stepped_op)
  );

  always_comb begin
    dir_ready = !busy && !start && out_ready;
    out_valid = busy || (dir_valid && !start);
    out_instr = busy ? stepped_op : dir_instr;
  end

  AST_DIR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dir_ready); // R8
  AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |-> !dir_ready && !out_valid); // R9
  AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !out_ready |=> out_valid); // R7
endmodule

// File: tb/sim_bitser_macro_seq.sv
module sim_bitser_macro_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        uc_we = 1'b0;
  logic [5:0]  uc_waddr = '0;
  logic [42:0] uc_wdata = '0;
  logic        start = 1'b0;
  logic [5:0]  start_addr = '0;
  logic        dir_valid = 1'b0;
  logic [34:0] dir_instr = '0;
  logic        out_ready = 1'b0;
  logic        dir_ready, out_valid, busy, done;
  logic [34:0] out_instr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bitser_macro_seq u0 (
    .clk(clk), .rst_n(rst_n), .uc_we(uc_we), .uc_waddr(uc_waddr), .uc_wdata(uc_wdata),
    .start(start), .start_addr(start_addr), .dir_valid(dir_valid), .dir_instr(dir_instr),
    .dir_ready(dir_ready), .out_valid(out_valid), .out_instr(out_instr),
    .out_ready(out_ready), .busy(busy), .done(done)
  );

  // Behavioural reference model
  logic [42:0] m_mem [64];
  int m_busy = 0, m_done = 0, m_pc = 0, m_off = 0;

  function automatic logic [34:0] stepped(input logic [42:0] w, input int k);
    logic [34:0] r;
    r = w[34:0];
    r[6:0] = 7'((int'(w[6:0]) + k) % 128);
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_pc = 0; m_off = 0;
    end else begin
      m_done = 0;
      if (m_busy != 0) begin
        if (out_ready) begin
          if (m_off == int'(m_mem[m_pc][41:35])) begin
            m_off = 0;
            if (m_mem[m_pc][42]) begin m_busy = 0; m_done = 1; end
            else m_pc = (m_pc + 1) % 64;
          end else m_off = m_off + 1;
        end
      end else if (start) begin
        m_busy = 1; m_pc = int'(start_addr); m_off = 0;
      end
      if (uc_we) m_mem[uc_waddr] = uc_wdata;
    end
  end

  task automatic chk(input string tag, input logic [34:0] act, input logic [34:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic e_valid, e_dready;
    e_valid  = (m_busy != 0) || (dir_valid && !start);
    e_dready = (m_busy == 0) && !start && out_ready;
    chk("R2 out_valid", 35'(out_valid), 35'(e_valid));
    chk("R6 busy", 35'(busy), 35'(m_busy != 0));
    chk("R5 done", 35'(done), 35'(m_done != 0));
    chk(start ? "R9 dir_ready" : "R8 dir_ready", 35'(dir_ready), 35'(e_dready));
    if (m_busy != 0) begin
      if (!out_ready) chk("R7 held instr", out_instr, stepped(m_mem[m_pc], m_off));
      else if (m_off > 0) chk("R4 stepped instr", out_instr, stepped(m_mem[m_pc], m_off));
      else chk("R3 instr order", out_instr, stepped(m_mem[m_pc], m_off));
    end else if (dir_valid && !start) begin
      chk("R8 direct instr", out_instr, dir_instr);
    end
  endtask

  task automatic step();
    #2 compare();
    @(negedge clk);
  endtask

  task automatic wr(input int a, input bit last, input int rep, input logic [34:0] op);
    uc_we = 1'b1; uc_waddr = 6'(a); uc_wdata = {last, 7'(rep), op};
    step();
    uc_we = 1'b0;
  endtask

  task automatic run_out(input int limit);
    for (int i = 0; i < limit && busy; i++) step();
    step(); step();
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 busy", 35'(busy), 35'(0));
    chk("R1 done", 35'(done), 35'(0));
    chk("R1 out_valid", 35'(out_valid), 35'(0));
    rst_n = 1'b1;
    out_ready = 1'b1;
    step();
    chk("R1 idle after release", 35'(busy | done | out_valid), 35'(0));
    // R10 load routines
    for (int i = 0; i < 64; i++) wr(i, 1'b1, 0, 35'(i * 4099));
    wr(0, 1'b0, 0, 35'h0_1000_0000);
    wr(1, 1'b1, 7, 35'h2_3400_0010);
    wr(10, 1'b1, 127, 35'h4_5600_0078);
    wr(20, 1'b0, 0, 35'h1_1111_1101);
    wr(21, 1'b0, 2, 35'h2_2222_227E);
    wr(22, 1'b1, 0, 35'h3_3333_3303);

    // R2 start add routine; R6 start while busy
    start = 1'b1; start_addr = 6'd0;
    step();
    start = 1'b0;
    #1 chk("R2 first word", out_instr, 35'h0_1000_0000);
    for (int i = 0; i < 4; i++) step();
    start = 1'b1; start_addr = 6'd20;
    step(); step();
    start = 1'b0;
    run_out(40);

    // R4 long copy with wrap, random back-pressure (R7)
    start = 1'b1; start_addr = 6'd10;
    step();
    start = 1'b0;
    for (int i = 0; i < 600 && busy; i++) begin
      out_ready = ($urandom % 3) != 0;
      step();
    end
    out_ready = 1'b1;
    run_out(10);

    // R8 direct broadcast while idle
    for (int i = 0; i < 8; i++) begin
      dir_valid = 1'b1; dir_instr = 35'(35'h5_0000_0000 + i * 977);
      out_ready = (i % 3) != 1;
      step();
    end
    out_ready = 1'b1;

    // R9 start and direct together, then direct blocked while busy (R8)
    start = 1'b1; start_addr = 6'd20; dir_instr = 35'h7_7777_7777;
    step();
    start = 1'b0;
    // R7 long stall at routine start
    out_ready = 1'b0;
    for (int i = 0; i < 10; i++) step();
    out_ready = 1'b1;
    run_out(20);
    dir_valid = 1'b0;

    // R10 rewrite word 21 and rerun
    wr(21, 1'b0, 3, 35'h6_0000_0040);
    start = 1'b1; start_addr = 6'd20;
    step();
    start = 1'b0;
    step();
    #1 chk("R10 new contents", out_instr, 35'h6_0000_0040);
    run_out(20);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule